// File: doc/BRIEF.md
# Paged SRAM address selector

This block builds the full data-memory address for a small 8-bit processor whose SRAM is split into 256-byte pages. Every access presents an 8-bit offset and a kind tag (direct, indexed, stack or register space). The block returns the page number that goes above that offset. It chooses the page from a two-bit paging mode held in a flags register and from three page pointers: current, stack and index.

Direct and indexed accesses resolve their pages separately, so one mode value can send ordinary variables to one page and indexed data to another. Stack accesses always use the stack page pointer. Register-space accesses bypass paging.

When an interrupt is taken, the block stores the flags in a small last-in-first-out save area and clears the live flags, so the handler starts in mode 00. On interrupt return, the saved value comes back even if the handler rewrote the mode. The page pointers are never saved or restored, and they keep whatever the handler last wrote. The address path is combinational from registered state. Register writes take effect on the following cycle.

Top module: `paged_addr_sel`

## Requirements
- R1: After a synchronous active-low reset, the flags and all three page pointers are zero, so every memory access of any kind resolves to page 0.
- R2: With mode field (flags bits 7:6) equal to 00, direct (kind 0) and indexed (kind 1) accesses both go to page 0.
- R3: With mode 01, direct accesses go to page 0 and indexed accesses go to the stack page pointer's page.
- R4: With mode 10, direct accesses go to the current page pointer's page and indexed accesses go to the index page pointer's page.
- R5: With mode 11, direct accesses go to the current page pointer's page and indexed accesses go to the stack page pointer's page.
- R6: Stack accesses (kind 2) always go to the stack page pointer's page, in every mode.
- R7: Register-space accesses (kind 3) drive mem_sel low and output the offset with a zero page field. The other kinds drive mem_sel high. The address is {page, offset}.
- R8: A write with reg_sel 0 loads the whole flags byte. Selects 1, 2 and 3 load the current, stack and index pointers from the low 3 data bits. Each new value is seen from the next cycle on.
- R9: irq_enter saves the flags and reads the flags as zero from the next cycle. A flags write in the same cycle is discarded.
- R10: irq_exit restores the most recently saved flags on the next cycle, regardless of any change the handler made. A same-cycle flags write or irq_enter is discarded.
- R11: Interrupt entry and return leave all three page pointers unchanged, and pointer writes in that same cycle still take effect.
- R12: Saves nest in last-in-first-out order up to SAVE_DEPTH levels. An entry beyond that depth saves nothing. A return with nothing saved loads zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 flags, 1 current, 2 stack, 3 index pointer |
| reg_wdata | input | 8 | Write data |
| irq_enter | input | 1 | Interrupt entry pulse: save and clear flags |
| irq_exit | input | 1 | Interrupt return pulse: restore flags |
| acc_kind | input | 2 | Access kind: 0 direct, 1 indexed, 2 stack, 3 register space |
| acc_offset | input | 8 | Offset within the page |
| mem_addr | output | 11 | Resolved address {page, offset} |
| mem_sel | output | 1 | High for SRAM accesses, low for register space |
| flags_q | output | 8 | Live flags register |

## Verification
A flags write can fall in the same cycle as interrupt entry or interrupt return, and entry can also coincide with return. Directed cycles force each of these pairs. Randomly generated write, entry and return pulses then overlap them again many times. The bench model applies the stated precedence (return over entry over a flags write) and compares the live flags and the resolved page on every following cycle. The page pointers are also written across these same cycles to confirm they are neither saved nor blocked.

// File: rtl/pgsel_pkg.sv
// Package: shared encodings for the paged SRAM address selector.
// Assumes: a two-bit access kind and a two-bit register select.
package pgsel_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_INDEX  = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_REGIO  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_CUR   = 2'd1,
        SEL_STK   = 2'd2,
        SEL_IDX   = 2'd3
    } reg_sel_e;

    localparam int PTR_CUR = 0;
    localparam int PTR_STK = 1;
    localparam int PTR_IDX = 2;
    localparam int NUM_PTR = 3;
endpackage

// File: rtl/pgsel_ptr_regs.sv
// Module: the three page pointer registers (current, stack, index).
// Assumes: reg_sel 1..3 map to pointers 0..2; pointers ignore interrupts.
module pgsel_ptr_regs
    import pgsel_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_we,
    input  logic [1:0]                      reg_sel,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [NUM_PTR-1:0][PAGE_W-1:0]  ptr_q
);
    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
        localparam logic [1:0] MY_SEL = 2'(gi + 1);
        // Purpose: load one pointer from the low data bits when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[gi] <= '0;
            end else if (reg_we && (reg_sel == MY_SEL)) begin
                ptr_q[gi] <= reg_wdata[PAGE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pgsel_flag_ctl.sv
// Module: flags register with interrupt save/clear/restore.
// Assumes: return beats entry, entry beats a flags write; saves are
// kept in a LIFO of SAVE_DEPTH entries; overflow saves are dropped.
module pgsel_flag_ctl #(
    parameter int FLAG_W     = 8,
    parameter int SAVE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              irq_enter,
    input  logic              irq_exit,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int CNT_W = $clog2(SAVE_DEPTH + 1);
    localparam int IDX_W = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1;

    logic [FLAG_W-1:0] save_mem [SAVE_DEPTH];
    logic [CNT_W-1:0]  depth_q;
    logic [IDX_W-1:0]  push_idx;
    logic [IDX_W-1:0]  pop_idx;
    logic              have_saved;
    logic              room_left;

    // Purpose: derive save-area indices and occupancy flags.
    always_comb begin
        push_idx   = IDX_W'(depth_q);
        pop_idx    = IDX_W'(depth_q - CNT_W'(1));
        have_saved = (depth_q != '0);
        room_left  = (depth_q < CNT_W'(SAVE_DEPTH));
    end

    // Purpose: update live flags and occupancy with stated precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            depth_q <= '0;
        end else if (irq_exit) begin
            if (have_saved) begin
                flags_q <= save_mem[pop_idx];
                depth_q <= depth_q - CNT_W'(1);
            end else begin
                flags_q <= '0;
            end
        end else if (irq_enter) begin
            flags_q <= '0;
            if (room_left) begin
                depth_q <= depth_q + CNT_W'(1);
            end
        end else if (flag_we) begin
            flags_q <= flag_wdata;
        end
    end

    // Purpose: store the outgoing flags into the save area on entry.
    always_ff @(posedge clk) begin
        if (rst_n && irq_enter && !irq_exit && room_left) begin
            save_mem[push_idx] <= flags_q;
        end
    end
endmodule

// File: rtl/pgsel_page_mux.sv
// Module: combinational page choice from access kind, mode and pointers.
// Assumes: mode bit 1 governs direct accesses; register space is unpaged.
module pgsel_page_mux
    import pgsel_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic [1:0]                      acc_kind,
    input  logic [1:0]                      mode,
    input  logic [NUM_PTR-1:0][PAGE_W-1:0]  ptr_q,
    output logic [PAGE_W-1:0]               page,
    output logic                            is_mem
);
    acc_kind_e kind;

    // Purpose: select the page number for this access.
    always_comb begin
        kind   = acc_kind_e'(acc_kind);
        page   = '0;
        is_mem = 1'b1;
        unique case (kind)
            ACC_DIRECT: page = mode[1] ? ptr_q[PTR_CUR] : '0;
            ACC_INDEX: begin
                unique case (mode)
                    2'b00:   page = '0;
                    2'b10:   page = ptr_q[PTR_IDX];
                    default: page = ptr_q[PTR_STK];
                endcase
            end
            ACC_STACK:  page = ptr_q[PTR_STK];
            ACC_REGIO: begin
                page   = '0;
                is_mem = 1'b0;
            end
            default:    page = '0;
        endcase
    end
endmodule

// File: rtl/paged_addr_sel.sv
// Module: top of the paged SRAM address selector.
// Assumes: mode field sits at flags[MODE_LSB+1:MODE_LSB]; address out is
// {page, offset}, combinational from registered state.
module paged_addr_sel
    import pgsel_pkg::*;
#(
    parameter int PAGE_W     = 3,
    parameter int OFFSET_W   = 8,
    parameter int FLAG_W     = 8,
    parameter int MODE_LSB   = 6,
    parameter int SAVE_DEPTH = 4,
    localparam int ADDR_W    = PAGE_W + OFFSET_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [FLAG_W-1:0]   reg_wdata,
    input  logic                irq_enter,
    input  logic                irq_exit,
    input  logic [1:0]          acc_kind,
    input  logic [OFFSET_W-1:0] acc_offset,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_sel,
    output logic [FLAG_W-1:0]   flags_q
);
    logic [NUM_PTR-1:0][PAGE_W-1:0] ptr_q;
    logic [PAGE_W-1:0]              page;
    logic [1:0]                     mode;
    logic                           flag_we;
    logic [PAGE_W-1:0]              cur_page_w;
    logic [PAGE_W-1:0]              stk_page_w;
    logic [PAGE_W-1:0]              idx_page_w;

    // Purpose: decode flags write and expose pointers and mode.
    always_comb begin
        flag_we    = reg_we && (reg_sel == SEL_FLAGS);
        mode       = flags_q[MODE_LSB+1:MODE_LSB];
        cur_page_w = ptr_q[PTR_CUR];
        stk_page_w = ptr_q[PTR_STK];
        idx_page_w = ptr_q[PTR_IDX];
    end

    pgsel_ptr_regs #(.PAGE_W(PAGE_W), .DATA_W(FLAG_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ptr_q     (ptr_q)
    );

    pgsel_flag_ctl #(.FLAG_W(FLAG_W), .SAVE_DEPTH(SAVE_DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_we    (flag_we),
        .flag_wdata (reg_wdata),
        .irq_enter  (irq_enter),
        .irq_exit   (irq_exit),
        .flags_q    (flags_q)
    );

    pgsel_page_mux #(.PAGE_W(PAGE_W)) u_mux (
        .acc_kind (acc_kind),
        .mode     (mode),
        .ptr_q    (ptr_q),
        .page     (page),
        .is_mem   (mem_sel)
    );

    // Purpose: join page and offset into the final address.
    always_comb begin
        mem_addr = {page, acc_offset};
    end
endmodule

// File: rtl/paged_addr_sel_chk.sv
// Module: assertion checker bound to paged_addr_sel.
// Assumes: bound with the top's own parameters and pointer wires.
module paged_addr_sel_chk #(
    parameter int PAGE_W   = 3,
    parameter int OFFSET_W = 8,
    parameter int FLAG_W   = 8,
    parameter int MODE_LSB = 6,
    localparam int ADDR_W  = PAGE_W + OFFSET_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [1:0]          reg_sel,
    input logic [FLAG_W-1:0]   reg_wdata,
    input logic                irq_enter,
    input logic                irq_exit,
    input logic [1:0]          acc_kind,
    input logic [OFFSET_W-1:0] acc_offset,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_sel,
    input logic [FLAG_W-1:0]   flags_q,
    input logic [PAGE_W-1:0]   cur_page,
    input logic [PAGE_W-1:0]   stk_page,
    input logic [PAGE_W-1:0]   idx_page
);
    logic [1:0]        mode;
    logic [PAGE_W-1:0] pg;
    assign mode = flags_q[MODE_LSB+1:MODE_LSB];
    assign pg   = mem_addr[ADDR_W-1:OFFSET_W];

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0) && (cur_page == '0) && (stk_page == '0) && (idx_page == '0));

    assert_mode0_page0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) && (acc_kind == 2'd0 || acc_kind == 2'd1) |-> pg == '0);

    assert_upper_bit_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] && (acc_kind == 2'd0) |-> pg == cur_page);

    assert_stack_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd2) |-> (pg == stk_page) && mem_sel);

    assert_regio_unpaged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd3) |-> !mem_sel && (pg == '0) && (mem_addr[OFFSET_W-1:0] == acc_offset));

    assert_cur_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_sel == 2'd1) |=> cur_page == $past(reg_wdata[PAGE_W-1:0]));

    assert_enter_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter && !irq_exit |=> flags_q == '0);

    assert_ptrs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter || irq_exit) && !reg_we |=>
            $stable(cur_page) && $stable(stk_page) && $stable(idx_page));
endmodule

bind paged_addr_sel paged_addr_sel_chk #(
    .PAGE_W   (PAGE_W),
    .OFFSET_W (OFFSET_W),
    .FLAG_W   (FLAG_W),
    .MODE_LSB (MODE_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .irq_enter  (irq_enter),
    .irq_exit   (irq_exit),
    .acc_kind   (acc_kind),
    .acc_offset (acc_offset),
    .mem_addr   (mem_addr),
    .mem_sel    (mem_sel),
    .flags_q    (flags_q),
    .cur_page   (cur_page_w),
    .stk_page   (stk_page_w),
    .idx_page   (idx_page_w)
);

// File: tb/paged_addr_sel_tb.sv
`timescale 1ns/1ps
module paged_addr_sel_tb;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        irq_enter = 1'b0;
    logic        irq_exit = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [7:0]  acc_offset = '0;
    logic [10:0] mem_addr;
    logic        mem_sel;
    logic [7:0]  flags_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_flags = '0;
    logic [2:0] m_cur = '0, m_stk = '0, m_idx = '0;
    logic [7:0] m_save [DEPTH];
    int         m_depth = 0;

    always #2.5 clk = ~clk;

    paged_addr_sel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .irq_enter(irq_enter), .irq_exit(irq_exit),
        .acc_kind(acc_kind), .acc_offset(acc_offset), .mem_addr(mem_addr),
        .mem_sel(mem_sel), .flags_q(flags_q)
    );

    function automatic logic [2:0] exp_page(input logic [1:0] kind);
        logic [1:0] md;
        md = m_flags[7:6];
        case (kind)
            2'd0:    return md[1] ? m_cur : 3'd0;
            2'd1:    return (md == 2'b00) ? 3'd0 : (md == 2'b10) ? m_idx : m_stk;
            2'd2:    return m_stk;
            default: return 3'd0;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] kind);
        if (kind == 2'd2) return "R6";
        if (kind == 2'd3) return "R7";
        case (m_flags[7:6])
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs, then advance model at posedge.
    task automatic cycle(input logic we, input logic [1:0] sel, input logic [7:0] wd,
                         input logic ent, input logic ext,
                         input logic [1:0] kind, input logic [7:0] off, input string ftag);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        irq_enter = ent; irq_exit = ext; acc_kind = kind; acc_offset = off;
        #1;
        check(tag_for(kind), {21'd0, mem_addr}, {21'd0, exp_page(kind), off});
        check("R7", {31'd0, mem_sel}, {31'd0, kind != 2'd3});
        check(ftag, {24'd0, flags_q}, {24'd0, m_flags});
        @(posedge clk);
        if (we && sel == 2'd1) m_cur = wd[2:0];
        if (we && sel == 2'd2) m_stk = wd[2:0];
        if (we && sel == 2'd3) m_idx = wd[2:0];
        if (ext) begin
            if (m_depth > 0) begin m_depth--; m_flags = m_save[m_depth]; end
            else m_flags = '0;
        end else if (ent) begin
            if (m_depth < DEPTH) begin m_save[m_depth] = m_flags; m_depth++; end
            m_flags = '0;
        end else if (we && sel == 2'd0) begin
            m_flags = wd;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        check("R1", {24'd0, flags_q}, 32'd0);
        acc_kind = 2'd2; acc_offset = 8'h5A; #1;
        check("R1", {21'd0, mem_addr}, 32'h05A);
        rst_n = 1'b1;
        // R8: pointer and flag writes visible next cycle
        cycle(1, 2'd1, 8'h05, 0, 0, 2'd0, 8'h10, "R8");
        cycle(1, 2'd2, 8'h03, 0, 0, 2'd0, 8'h11, "R8");
        cycle(1, 2'd3, 8'h06, 0, 0, 2'd2, 8'h12, "R8");
        cycle(1, 2'd0, 8'h80, 0, 0, 2'd1, 8'h13, "R8");
        // R4 direct/indexed under mode 10
        cycle(0, 2'd0, 8'h00, 0, 0, 2'd0, 8'h20, "R4");
        cycle(0, 2'd0, 8'h00, 0, 0, 2'd1, 8'h21, "R4");
        // R9: entry with same-cycle flags write (write discarded)
        cycle(1, 2'd0, 8'hC0, 1, 0, 2'd1, 8'h22, "R9");
        cycle(1, 2'd0, 8'h40, 0, 0, 2'd1, 8'h23, "R9");
        // R11: pointer write during nested entry still lands; pointers not saved
        cycle(1, 2'd2, 8'h07, 1, 0, 2'd2, 8'h24, "R11");
        cycle(0, 2'd0, 8'h00, 0, 1, 2'd2, 8'h25, "R11");
        // R10: return with flags write and entry in same cycle
        cycle(1, 2'd0, 8'hFF, 1, 1, 2'd1, 8'h26, "R10");
        cycle(0, 2'd0, 8'h00, 0, 0, 2'd0, 8'h27, "R10");
        // R12: overflow the save area and drain past empty
        for (int i = 0; i < DEPTH + 2; i++) begin
            cycle(1, 2'd0, 8'(i * 64 + 1), 0, 0, 2'd3, 8'(i), "R12");
            cycle(0, 2'd0, 8'h00, 1, 0, 2'd0, 8'(i), "R12");
        end
        for (int i = 0; i < DEPTH + 2; i++)
            cycle(0, 2'd0, 8'h00, 0, 1, 2'd1, 8'(i), "R12");
        cycle(0, 2'd0, 8'h00, 0, 0, 2'd1, 8'h30, "R12");
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)), 8'($urandom),
                  ($urandom_range(0, 11) == 0), ($urandom_range(0, 11) == 0),
                  2'($urandom_range(0, 3)), 8'($urandom), "R10");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule